// File: doc/BRIEF.md
# Memory Monitor and Display Selector

This block is the front panel of a small accumulator CPU whose program and data live in a 256-word RAM with 16-bit words. When the monitor flag is high, the panel takes the RAM port away from the CPU. An 8-bit user address register then selects the word being looked at. A step button moves that address forward by one, or loads it from the switch bank when any switch is up. Two write buttons each patch one byte of the addressed word with the switch value and leave the other byte as it was.

When the monitor flag is low, the CPU drives the RAM port and the LEDs show its program counter. A priority chain on the upper five switches picks which CPU quantity appears on the 16-bit hex display. With none of those switches up, the display shows the CPU's output register. Digit scanning is left to a separate driver. The user address register keeps its value across mode changes, so the same value can also serve as a breakpoint address.

Top module: `panel_monitor`

## Requirements
- R1: While reset is asserted and after it is released, the user address is 0 and no write has been issued. In monitor mode the LEDs read 0x00 and the display shows word 0.
- R2: In monitor mode, the RAM address and the LEDs both equal the user address. RAM writes come only from the write buttons.
- R3: In monitor mode, a rising edge of the step button with all switches at 0 adds one to the user address, and 0xFF steps to 0x00. The address changes at the clock edge that samples the press.
- R4: In monitor mode, a rising edge of the step button with a non-zero switch value loads that value as the user address. The address then holds until the next step press, whatever the switches do.
- R5: In monitor mode, a rising edge of the low-byte write button writes the addressed word with bits 7:0 set to the switches and bits 15:8 kept.
- R6: In monitor mode, a rising edge of the high-byte write button writes bits 15:8 from the switches and keeps bits 7:0. When both write buttons rise in the same cycle, both bytes take the switch value.
- R7: Each write press gives exactly one cycle of RAM write enable, however long the button is held. Switch changes while the button is held do not reach memory.
- R8: In monitor mode, the display shows the RAM read data. While the step button is held, it shows the user address zero-extended to 16 bits instead.
- R9: Outside monitor mode, the RAM address, write data and write enable follow the CPU inputs, and the LEDs show the CPU program counter. The panel buttons change neither the user address nor memory.
- R10: Outside monitor mode, the display is chosen by priority, highest first:
  - switch 7 shows {PC, CPU memory address};
  - switch 6 shows IR;
  - switch 5 shows RAM read data;
  - switch 4 shows AC.
- R11: Outside monitor mode with switches 7..4 low, switch 3 shows the 4-bit state code in bits 3:0 with bits 15:4 at zero. With switches 7..3 all low, the display shows the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_mode | input | 1 | High: panel owns the RAM port |
| btn_step | input | 1 | Step / address-load button, debounced, synchronous |
| btn_wr_lo | input | 1 | Low-byte write button |
| btn_wr_hi | input | 1 | High-byte write button |
| sw | input | 8 | Switch bank |
| cpu_pc | input | 8 | CPU program counter |
| cpu_mem_addr | input | 8 | CPU RAM address |
| cpu_mem_wdata | input | 16 | CPU RAM write data |
| cpu_mem_we | input | 1 | CPU RAM write enable |
| cpu_ir | input | 16 | CPU instruction register |
| cpu_ac | input | 16 | CPU accumulator |
| cpu_state | input | 4 | CPU sequencer state code |
| cpu_out | input | 16 | CPU output register |
| ram_rdata | input | 16 | RAM asynchronous read data |
| ram_addr | output | 8 | RAM address |
| ram_wdata | output | 16 | RAM write data |
| ram_we | output | 1 | RAM write enable |
| led | output | 8 | LED value |
| disp | output | 16 | Four-hex-digit display value |

## Verification
The assertions assume that the buttons are already synchronous and debounced. They also assume that the RAM read data settles to the addressed word within the cycle, so a patch word built from it describes memory at the write edge. The bench changes every button, switch and mode input only at the falling clock edge, and its RAM model reads asynchronously and writes on the rising edge. It also keeps the CPU write enable low whenever the test expects memory to stay unchanged outside monitor mode.

// File: rtl/panel_pkg.sv
package panel_pkg;
  localparam int BYTE_W  = 8;
  localparam int STATE_W = 4;
  localparam int N_BTN   = 3;

  // display source codes, lowest priority first
  typedef enum logic [2:0] {
    VIEW_OUT    = 3'd0,
    VIEW_STATE  = 3'd1,
    VIEW_AC     = 3'd2,
    VIEW_RDATA  = 3'd3,
    VIEW_IR     = 3'd4,
    VIEW_PCADDR = 3'd5
  } view_e;

  // button vector positions
  localparam int BTN_STEP = 0;
  localparam int BTN_LO   = 1;
  localparam int BTN_HI   = 2;
endpackage

// File: rtl/pm_edge.sv
module pm_edge #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl[g];
    end
    assign rise[g] = lvl[g] & ~prev_q;
  end
endmodule

// File: rtl/pm_addr.sv
module pm_addr #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_en,
  input  logic [AW-1:0] sw,
  output logic [AW-1:0] addr
);
  // zero switches advance (wrapping), anything else is a direct entry
  function automatic logic [AW-1:0] next_addr(input logic [AW-1:0] cur,
                                              input logic [AW-1:0] swv);
    if (swv == '0) return AW'(cur + 1'b1);
    return swv;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr <= '0;
    else if (step_en) addr <= next_addr(addr, sw);
  end
endmodule

// File: rtl/pm_patch.sv
module pm_patch #(
  parameter int BW = 8,
  localparam int WW = 2 * BW
) (
  input  logic [WW-1:0] rd,
  input  logic [BW-1:0] sw,
  input  logic          lo,
  input  logic          hi,
  output logic [WW-1:0] wd
);
  function automatic logic [WW-1:0] merge(input logic [WW-1:0] word,
                                          input logic [BW-1:0] b,
                                          input logic take_lo,
                                          input logic take_hi);
    logic [BW-1:0] up, dn;
    up = take_hi ? b : word[WW-1:BW];
    dn = take_lo ? b : word[BW-1:0];
    return {up, dn};
  endfunction

  assign wd = merge(rd, sw, lo, hi);
endmodule

// File: rtl/pm_view.sv
module pm_view
  import panel_pkg::*;
#(
  parameter int BW   = 8,
  parameter int ST_W = 4,
  localparam int WW  = 2 * BW
) (
  input  logic            mon_mode,
  input  logic            step_held,
  input  logic [BW-1:0]   user_addr,
  input  logic [BW-1:0]   sw,
  input  logic [BW-1:0]   cpu_pc,
  input  logic [BW-1:0]   cpu_mem_addr,
  input  logic [WW-1:0]   cpu_ir,
  input  logic [WW-1:0]   cpu_ac,
  input  logic [ST_W-1:0] cpu_state,
  input  logic [WW-1:0]   cpu_out,
  input  logic [WW-1:0]   ram_rdata,
  output view_e           view,
  output logic [BW-1:0]   led,
  output logic [WW-1:0]   disp
);
  // top five switches form the priority chain
  function automatic view_e pick(input logic [BW-1:0] s);
    if (s[BW-1]) return VIEW_PCADDR;
    if (s[BW-2]) return VIEW_IR;
    if (s[BW-3]) return VIEW_RDATA;
    if (s[BW-4]) return VIEW_AC;
    if (s[BW-5]) return VIEW_STATE;
    return VIEW_OUT;
  endfunction

  assign view = pick(sw);

  always_comb begin
    if (mon_mode) begin
      led  = user_addr;
      disp = step_held ? {{BW{1'b0}}, user_addr} : ram_rdata;
    end else begin
      led = cpu_pc;
      unique case (view)
        VIEW_PCADDR: disp = {cpu_pc, cpu_mem_addr};
        VIEW_IR:     disp = cpu_ir;
        VIEW_RDATA:  disp = ram_rdata;
        VIEW_AC:     disp = cpu_ac;
        VIEW_STATE:  disp = {{(WW-ST_W){1'b0}}, cpu_state};
        default:     disp = cpu_out;
      endcase
    end
  end
endmodule

// File: rtl/panel_monitor.sv
module panel_monitor
  import panel_pkg::*;
#(
  parameter int BW   = panel_pkg::BYTE_W,
  parameter int ST_W = panel_pkg::STATE_W,
  localparam int WW  = 2 * BW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mon_mode,
  input  logic            btn_step,
  input  logic            btn_wr_lo,
  input  logic            btn_wr_hi,
  input  logic [BW-1:0]   sw,
  input  logic [BW-1:0]   cpu_pc,
  input  logic [BW-1:0]   cpu_mem_addr,
  input  logic [WW-1:0]   cpu_mem_wdata,
  input  logic            cpu_mem_we,
  input  logic [WW-1:0]   cpu_ir,
  input  logic [WW-1:0]   cpu_ac,
  input  logic [ST_W-1:0] cpu_state,
  input  logic [WW-1:0]   cpu_out,
  input  logic [WW-1:0]   ram_rdata,
  output logic [BW-1:0]   ram_addr,
  output logic [WW-1:0]   ram_wdata,
  output logic            ram_we,
  output logic [BW-1:0]   led,
  output logic [WW-1:0]   disp
);
  logic [N_BTN-1:0] btn_rise;
  logic             step_evt, wr_lo_evt, wr_hi_evt;
  logic [BW-1:0]    user_addr;
  logic [WW-1:0]    patch_word;
  view_e            view;

  pm_edge #(.N(N_BTN)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  ({btn_wr_hi, btn_wr_lo, btn_step}),
    .rise (btn_rise)
  );

  assign step_evt  = btn_rise[BTN_STEP];
  assign wr_lo_evt = btn_rise[BTN_LO];
  assign wr_hi_evt = btn_rise[BTN_HI];

  pm_addr #(.AW(BW)) u_addr (
    .clk    (clk),
    .rst_n  (rst_n),
    .step_en(mon_mode & step_evt),
    .sw     (sw),
    .addr   (user_addr)
  );

  pm_patch #(.BW(BW)) u_patch (
    .rd(ram_rdata),
    .sw(sw),
    .lo(wr_lo_evt),
    .hi(wr_hi_evt),
    .wd(patch_word)
  );

  pm_view #(.BW(BW), .ST_W(ST_W)) u_view (
    .mon_mode    (mon_mode),
    .step_held   (btn_step),
    .user_addr   (user_addr),
    .sw          (sw),
    .cpu_pc      (cpu_pc),
    .cpu_mem_addr(cpu_mem_addr),
    .cpu_ir      (cpu_ir),
    .cpu_ac      (cpu_ac),
    .cpu_state   (cpu_state),
    .cpu_out     (cpu_out),
    .ram_rdata   (ram_rdata),
    .view        (view),
    .led         (led),
    .disp        (disp)
  );

  // RAM port ownership
  assign ram_addr  = mon_mode ? user_addr : cpu_mem_addr;
  assign ram_wdata = mon_mode ? patch_word : cpu_mem_wdata;
  assign ram_we    = mon_mode ? (wr_lo_evt | wr_hi_evt) : cpu_mem_we;
endmodule

// File: rtl/panel_monitor_chk.sv
module panel_monitor_chk #(
  parameter int BW   = 8,
  parameter int ST_W = 4,
  localparam int WW  = 2 * BW
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mon_mode,
  input logic [BW-1:0]   sw,
  input logic            step_evt,
  input logic            wr_lo_evt,
  input logic            wr_hi_evt,
  input logic [BW-1:0]   user_addr,
  input logic [WW-1:0]   ram_rdata,
  input logic [BW-1:0]   ram_addr,
  input logic [WW-1:0]   ram_wdata,
  input logic            ram_we,
  input logic [BW-1:0]   cpu_mem_addr,
  input logic            cpu_mem_we,
  input logic [BW-1:0]   cpu_pc,
  input logic [ST_W-1:0] cpu_state,
  input logic [BW-1:0]   led,
  input logic [WW-1:0]   disp
);
  p_port_mon_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mon_mode |-> (ram_addr == user_addr) && (led == user_addr));

  p_step_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mon_mode && step_evt && (sw == '0) |=> user_addr == BW'($past(user_addr) + 1'b1));

  p_step_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mon_mode && step_evt && (sw != '0) |=> user_addr == $past(sw));

  p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mon_mode && step_evt) |=> $stable(user_addr));

  p_lo_patch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mon_mode && ram_we && wr_lo_evt && !wr_hi_evt |->
      ram_wdata == {ram_rdata[WW-1:BW], sw});

  p_hi_patch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mon_mode && ram_we && wr_hi_evt && !wr_lo_evt |->
      ram_wdata == {sw, ram_rdata[BW-1:0]});

  p_we_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mon_mode && ram_we |=> !(mon_mode && ram_we));

  p_cpu_port_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !mon_mode |-> (ram_addr == cpu_mem_addr) && (ram_we == cpu_mem_we) && (led == cpu_pc));

  p_state_view_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !mon_mode && (sw[BW-1:BW-5] == 5'b00001) |->
      disp == {{(WW-ST_W){1'b0}}, cpu_state});
endmodule

bind panel_monitor panel_monitor_chk #(.BW(BW), .ST_W(ST_W)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mon_mode    (mon_mode),
  .sw          (sw),
  .step_evt    (step_evt),
  .wr_lo_evt   (wr_lo_evt),
  .wr_hi_evt   (wr_hi_evt),
  .user_addr   (user_addr),
  .ram_rdata   (ram_rdata),
  .ram_addr    (ram_addr),
  .ram_wdata   (ram_wdata),
  .ram_we      (ram_we),
  .cpu_mem_addr(cpu_mem_addr),
  .cpu_mem_we  (cpu_mem_we),
  .cpu_pc      (cpu_pc),
  .cpu_state   (cpu_state),
  .led         (led),
  .disp        (disp)
);

// File: tb/test_panel_monitor.sv
`timescale 1ns/1ps
module test_panel_monitor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mon_mode = 1'b1;
  logic        btn_step = 1'b0, btn_wr_lo = 1'b0, btn_wr_hi = 1'b0;
  logic [7:0]  sw = 8'h00;
  logic [7:0]  cpu_pc = 8'h12, cpu_mem_addr = 8'h34;
  logic [15:0] cpu_mem_wdata = 16'h0000;
  logic        cpu_mem_we = 1'b0;
  logic [15:0] cpu_ir = 16'h0734, cpu_ac = 16'hbeef, cpu_out = 16'h0541;
  logic [3:0]  cpu_state = 4'h9;
  logic [15:0] ram_rdata;
  logic [7:0]  ram_addr, led;
  logic [15:0] ram_wdata, disp;
  logic        ram_we;

  int checks = 0, fails = 0, we_count = 0;

  always #5 clk = ~clk;

  panel_monitor i_panel_monitor (.*);

  // bench RAM: asynchronous read, write at rising edge
  logic [15:0] mem [256];
  function automatic logic [15:0] init_word(int i);
    return 16'((i * 259) ^ 16'ha5c3);
  endfunction
  initial for (int i = 0; i < 256; i++) mem[i] = init_word(i);
  assign ram_rdata = mem[ram_addr];
  always @(posedge clk) if (ram_we) begin
    mem[ram_addr] <= ram_wdata;
    we_count <= we_count + 1;
  end

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step_press(logic [7:0] s, logic [15:0] held_exp, string tag);
    @(negedge clk); sw = s; btn_step = 1'b1;
    @(negedge clk);
    if (mon_mode) chk(tag, disp, held_exp);
    btn_step = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr_press(logic lo, logic hi, logic [7:0] s, int hold);
    @(negedge clk); sw = s; btn_wr_lo = lo; btn_wr_hi = hi;
    for (int c = 0; c < hold; c++) begin
      @(negedge clk); sw = ~s;   // changes during hold must not land
    end
    btn_wr_lo = 1'b0; btn_wr_hi = 1'b0;
    @(negedge clk);
  endtask

  typedef struct packed { logic [7:0] s; logic [2:0] src; } vec_t;
  localparam vec_t VEC [0:8] = '{
    '{8'h00, 3'd0}, '{8'h08, 3'd1}, '{8'h07, 3'd0}, '{8'h18, 3'd2},
    '{8'h3f, 3'd3}, '{8'h6a, 3'd4}, '{8'hff, 3'd5}, '{8'h90, 3'd5},
    '{8'h48, 3'd4}};

  function automatic logic [15:0] view_exp(logic [2:0] src);
    case (src)
      3'd5: return {cpu_pc, cpu_mem_addr};
      3'd4: return cpu_ir;
      3'd3: return mem[cpu_mem_addr];
      3'd2: return cpu_ac;
      3'd1: return {12'h000, cpu_state};
      default: return cpu_out;
    endcase
  endfunction

  initial begin : watchdog
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    int wc;
    repeat (3) @(negedge clk);
    chk("R1 led in reset", {8'h00, led}, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 led after reset", {8'h00, led}, 16'h0000);
    chk("R1 display word0", disp, init_word(0));
    chk("R1 no writes", 16'(we_count), 16'h0000);

    // R3 increment, R8 held view
    step_press(8'h00, 16'h0001, "R8 held shows addr");
    chk("R3 incremented", {8'h00, led}, 16'h0001);
    chk("R2 ram_addr follows", {8'h00, ram_addr}, 16'h0001);
    chk("R8 shows word", disp, init_word(1));

    // R4 load and hold
    step_press(8'hfe, 16'h00fe, "R8 held shows loaded addr");
    @(negedge clk); sw = 8'h33; @(negedge clk);
    chk("R4 address held after switch change", {8'h00, led}, 16'h00fe);
    step_press(8'h00, 16'h00ff, "R8 held 0xff");
    step_press(8'h00, 16'h0000, "R3 held wrap");
    chk("R3 wrapped to 0", {8'h00, led}, 16'h0000);

    // R5 low byte
    step_press(8'h40, 16'h0040, "R4 held 0x40");
    wc = we_count;
    wr_press(1'b1, 1'b0, 8'h9c, 1);
    chk("R5 low byte patched", disp, {init_word(64)[15:8], 8'h9c});
    chk("R7 one pulse lo", 16'(we_count - wc), 16'd1);

    // R6 high byte, held long with switch changes (R7)
    wc = we_count;
    wr_press(1'b0, 1'b1, 8'h27, 4);
    chk("R6 high byte patched", disp, 16'h279c);
    chk("R7 one pulse while held", 16'(we_count - wc), 16'd1);

    wr_press(1'b1, 1'b1, 8'hc4, 1);
    chk("R6 both bytes", disp, 16'hc4c4);

    // R9 CPU owns the port, buttons have no effect
    @(negedge clk); mon_mode = 1'b0; sw = 8'h00;
    @(negedge clk);
    chk("R9 led is pc", {8'h00, led}, 16'h0012);
    chk("R9 ram_addr is cpu", {8'h00, ram_addr}, 16'h0034);
    wc = we_count;
    step_press(8'h77, 16'h0000, "unused");
    wr_press(1'b1, 1'b1, 8'h55, 1);
    chk("R9 no panel writes", 16'(we_count - wc), 16'd0);
    @(negedge clk); mon_mode = 1'b1;
    @(negedge clk);
    chk("R9 addr untouched", {8'h00, led}, 16'h0040);
    chk("R9 word untouched", disp, 16'hc4c4);

    // R9 CPU write path
    @(negedge clk); mon_mode = 1'b0; cpu_mem_wdata = 16'h1357; cpu_mem_we = 1'b1;
    @(negedge clk); cpu_mem_we = 1'b0; sw = 8'h3f;
    @(negedge clk);
    chk("R9 cpu write landed", disp, 16'h1357);

    // R10 / R11 priority table
    foreach (VEC[v]) begin
      @(negedge clk); sw = VEC[v].s;
      @(negedge clk);
      chk(VEC[v].src == 3'd1 ? "R11 state view" :
          VEC[v].src == 3'd0 ? "R11 out view" : "R10 priority view",
          disp, view_exp(VEC[v].src));
    end

    // reset mid-run returns address to 0 (R1)
    @(negedge clk); mon_mode = 1'b1; rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset clears addr", {8'h00, led}, 16'h0000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule